// File: doc/BRIEF.md
# Bit-Serial Processing-in-Memory Row Array

This block is a small memory of 16 rows by 32 columns in which every row has its own one-bit processing unit. A sequencer drives one microinstruction per clock to all rows at once. Each unit can load the bit of a chosen column into one of its one-bit registers, combine bits through a one-bit adder or a one-bit logic function, keep a carry between steps, and write a chosen register back into a chosen column. Multi-bit fields held in neighbouring columns are thus added, subtracted or combined bit by bit, least significant bit first, in every row in parallel. The time taken depends on the field width, not on how many rows there are.

Each row also has a condition register. A two-bit condition code from the sequencer uses it in three ways: to force a register load to zero, to pick which register a column write takes, and to decide which rows a word-wide sequential port may reach. A compare-immediate step sets the condition bit in rows whose field equals a key. The sequential port can then read or overwrite the flagged rows without knowing their row numbers.

Top module: `bsp_array`

## Requirements
- R1: After reset, every memory bit and every per-row register (three operand registers, the condition register and the carry) is 0, and the sequential port reads 0 from every row.
- R2: Encodings. `uop_op`: 0 idle, 1 load column into RA, 2 load column into RB, 3 load column into RC, 4 store to column, 5 ALU step, 6 clear carry, 7 set carry, 8 set condition bit, 9 compare-immediate step. `uop_src`: 0 RA, 1 RB, 2 RC, 3 carry. `uop_fn`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR. `cond_code`: 0 plain, 1 write-select, 2 row-mask, 3 plain. Column c of row r is bit c of that row's sequential word. A load in cycle t is visible to a store in cycle t+1, and a store changes memory at the end of its own cycle.
- R3: With condition code 0, loading RB in a row whose condition bit is 1 puts 0 into RB. Rows whose condition bit is 0 load the memory bit.
- R4: With condition code 1, a store writes RB in rows whose condition bit is 1 and RA in the other rows, whatever `uop_src` says. With any other code, the store writes the register named by `uop_src`.
- R5: With condition code 2, a sequential write reaches every row whose condition bit is 1 and leaves the other rows unchanged. A sequential read returns the OR of the words of all flagged rows, which is 0 when no row is flagged.
- R6: With condition codes 0, 1 and 3, the sequential port reads and writes the row at `seq_row`. Memory does not change in a cycle that has no store and no sequential write.
- R7: Add: clear carry, then for each bit i of an m-bit field, load A bit i into RA, run an ALU add on B bit i, and store RC into result bit i. A final store of the carry gives result bit m. The m+1-bit result equals A+B in every row, after 3m+2 cycles.
- R8: Subtract: the same sequence with the carry set at the start and the subtract function, which inverts the column bit. This gives (A-B) mod 2^m, and the final carry is 1 exactly when A is at least B.
- R9: An ALU step with AND, OR or XOR puts RA combined with the column bit into RC and leaves the carry unchanged.
- R10: Setting the condition bit and then running one compare-immediate step per key bit over a field leaves the condition bit 1 only in rows whose field equals the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| uop_op | input | 4 | Microinstruction operation (R2) |
| uop_col | input | 5 | Column addressed by the microinstruction |
| uop_src | input | 2 | Register a store takes (R2) |
| uop_fn | input | 3 | ALU function (R2) |
| uop_imm | input | 1 | Key bit for compare-immediate |
| cond_code | input | 2 | Condition code (R2) |
| seq_wr | input | 1 | Sequential port write strobe |
| seq_row | input | 4 | Sequential port row address |
| seq_wdata | input | 32 | Sequential port write word |
| seq_rdata | output | 32 | Sequential port read word (combinational) |

## Verification
The assertions assume that the sequencer never issues a store to the same column in the same cycle as a sequential write of that row. They also assume that operation, function and source codes stay inside the encoded sets. The stimulus issues sequential writes only in idle cycles, and only with the listed codes, so the column-write selection and the masked-port checks always see one writer per bit. Operand fields are placed in columns that never overlap the result field of the same sequence, so every load sees the value present before the sequence started.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_LDA    = 4'd1,
    OP_LDB    = 4'd2,
    OP_LDC    = 4'd3,
    OP_STORE  = 4'd4,
    OP_ALU    = 4'd5,
    OP_CLRC   = 4'd6,
    OP_SETC   = 4'd7,
    OP_TAGSET = 4'd8,
    OP_CMPI   = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    SRC_RA = 2'd0,
    SRC_RB = 2'd1,
    SRC_RC = 2'd2,
    SRC_CY = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0,
    FN_SUB = 3'd1,
    FN_AND = 3'd2,
    FN_OR  = 3'd3,
    FN_XOR = 3'd4
  } fn_e;

  localparam logic [1:0] CC_PLAIN = 2'b00;
  localparam logic [1:0] CC_WSEL  = 2'b01;
  localparam logic [1:0] CC_MASK  = 2'b10;
endpackage

// File: rtl/bsp_fg.sv
module bsp_fg
  import bsp_pkg::*;
(
  input  fn_e  fn,
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic res,
  output logic cout
);
  logic bx;

  always_comb begin
    bx   = (fn == FN_SUB) ? ~b : b;
    res  = 1'b0;
    cout = cin;
    case (fn)
      FN_ADD, FN_SUB: begin
        res  = a ^ bx ^ cin;
        cout = (a & bx) | (a & cin) | (bx & cin);
      end
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_XOR:  res = a ^ b;
      default: res = 1'b0;
    endcase
  end
endmodule

// File: rtl/bsp_pu.sv
module bsp_pu
  import bsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  op_e        op,
  input  src_e       src,
  input  fn_e        fn,
  input  logic [1:0] cc,
  input  logic       imm,
  input  logic       mem_bit,
  output logic       st_en,
  output logic       st_bit,
  output logic       ra_q,
  output logic       rb_q,
  output logic       rc_q,
  output logic       rd_q,
  output logic       cy_q
);
  logic ra_d, rb_d, rc_d, rd_d, cy_d;
  logic fg_res, fg_cout;
  logic reg_en;

  bsp_fg u_fg (
    .fn   (fn),
    .a    (ra_q),
    .b    (mem_bit),
    .cin  (cy_q),
    .res  (fg_res),
    .cout (fg_cout)
  );

  always_comb begin
    ra_d = ra_q;
    rb_d = rb_q;
    rc_d = rc_q;
    rd_d = rd_q;
    cy_d = cy_q;
    case (op)
      OP_LDA:    ra_d = mem_bit;
      OP_LDB:    rb_d = (cc == CC_PLAIN && rd_q) ? 1'b0 : mem_bit;
      OP_LDC:    rc_d = mem_bit;
      OP_ALU: begin
        rc_d = fg_res;
        cy_d = fg_cout;
      end
      OP_CLRC:   cy_d = 1'b0;
      OP_SETC:   cy_d = 1'b1;
      OP_TAGSET: rd_d = 1'b1;
      OP_CMPI:   rd_d = rd_q & ~(mem_bit ^ imm);
      default:   ;
    endcase
  end

  assign reg_en = (op != OP_NOP) && (op != OP_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= 1'b0;
      rb_q <= 1'b0;
      rc_q <= 1'b0;
      rd_q <= 1'b0;
      cy_q <= 1'b0;
    end else if (reg_en) begin
      ra_q <= ra_d;
      rb_q <= rb_d;
      rc_q <= rc_d;
      rd_q <= rd_d;
      cy_q <= cy_d;
    end
  end

  always_comb begin
    st_en = (op == OP_STORE);
    if (cc == CC_WSEL) begin
      st_bit = rd_q ? rb_q : ra_q;
    end else begin
      case (src)
        SRC_RA:  st_bit = ra_q;
        SRC_RB:  st_bit = rb_q;
        SRC_RC:  st_bit = rc_q;
        default: st_bit = cy_q;
      endcase
    end
  end
endmodule

// File: rtl/bsp_row.sv
module bsp_row #(
  parameter int COLS = 32,
  localparam int CW = $clog2(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   col,
  input  logic            simd_we,
  input  logic            simd_bit,
  input  logic            seq_we,
  input  logic [COLS-1:0] seq_wdata,
  output logic [COLS-1:0] q
);
  logic [COLS-1:0] q_d;
  logic            row_en;

  always_comb begin
    q_d = q;
    if (seq_we) q_d = seq_wdata;
    if (simd_we) q_d[col] = simd_bit;
  end

  assign row_en = simd_we | seq_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (row_en) q <= q_d;
  end
endmodule

// File: rtl/bsp_array.sv
module bsp_array
  import bsp_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      uop_op,
  input  logic [CW-1:0]   uop_col,
  input  logic [1:0]      uop_src,
  input  logic [2:0]      uop_fn,
  input  logic            uop_imm,
  input  logic [1:0]      cond_code,
  input  logic            seq_wr,
  input  logic [RW-1:0]   seq_row,
  input  logic [COLS-1:0] seq_wdata,
  output logic [COLS-1:0] seq_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  op_e  op;
  src_e src;
  fn_e  fn;
  assign op  = op_e'(uop_op);
  assign src = src_e'(uop_src);
  assign fn  = fn_e'(uop_fn);

  logic [COLS-1:0]      row_q [ROWS];
  logic [ROWS*COLS-1:0] mem_flat;
  logic [ROWS-1:0]      ra_vec, rb_vec, rc_vec, rd_vec, cy_vec;
  logic [ROWS-1:0]      st_en, st_bit, seq_we;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic col_bit;
    assign col_bit   = row_q[r][uop_col];
    assign seq_we[r] = seq_wr & ((cond_code == CC_MASK) ? rd_vec[r]
                                                        : (seq_row == RW'(r)));
    assign mem_flat[r*COLS +: COLS] = row_q[r];

    bsp_pu u_pu (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .op      (op),
      .src     (src),
      .fn      (fn),
      .cc      (cond_code),
      .imm     (uop_imm),
      .mem_bit (col_bit),
      .st_en   (st_en[r]),
      .st_bit  (st_bit[r]),
      .ra_q    (ra_vec[r]),
      .rb_q    (rb_vec[r]),
      .rc_q    (rc_vec[r]),
      .rd_q    (rd_vec[r]),
      .cy_q    (cy_vec[r])
    );

    bsp_row #(.COLS(COLS)) u_mem (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .col       (uop_col),
      .simd_we   (st_en[r]),
      .simd_bit  (st_bit[r]),
      .seq_we    (seq_we[r]),
      .seq_wdata (seq_wdata),
      .q         (row_q[r])
    );
  end

  always_comb begin
    seq_rdata = '0;
    if (cond_code == CC_MASK) begin
      for (int r = 0; r < ROWS; r++) begin
        if (rd_vec[r]) seq_rdata = seq_rdata | row_q[r];
      end
    end else begin
      seq_rdata = row_q[seq_row];
    end
  end
endmodule

// File: rtl/bsp_array_chk.sv
module bsp_array_chk #(
  parameter int ROWS = 16,
  parameter int COLS = 32,
  localparam int CW = $clog2(COLS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           op,
  input logic [1:0]           cc,
  input logic [CW-1:0]        col,
  input logic                 seq_wr,
  input logic [ROWS-1:0]      ra_vec,
  input logic [ROWS-1:0]      rb_vec,
  input logic [ROWS-1:0]      rd_vec,
  input logic [ROWS-1:0]      cy_vec,
  input logic [ROWS*COLS-1:0] mem_flat,
  input logic [COLS-1:0]      seq_rdata
);
  // R10: the set step flags every row
  a_r10_tag_all: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd8) |=> (&rd_vec));

  // R3: flagged rows load zero into RB under the plain code
  a_r3_cond_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2 && cc == 2'b00) |=> ((rb_vec & $past(rd_vec)) == '0));

  // R7: the carry clears
  a_r7_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd6) |=> (cy_vec == '0));

  // R8: the carry presets
  a_r8_carry_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |=> (&cy_vec));

  // R5: with no row flagged the masked read is empty
  a_r5_mask_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cc == 2'b10 && rd_vec == '0) |-> (seq_rdata == '0));

  // R6: memory holds without a writer
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 4'd4 && !seq_wr) |=> $stable(mem_flat));

  // R4: write-select stores RB in flagged rows and RA elsewhere
  for (genvar r = 0; r < ROWS; r++) begin : g_wsel
    a_r4_wsel: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 4'd4 && cc == 2'b01) |=>
        (mem_flat[r*COLS + int'($past(col))] ==
         ($past(rd_vec[r]) ? $past(rb_vec[r]) : $past(ra_vec[r]))));
  end
endmodule

bind bsp_array bsp_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op        (uop_op),
  .cc        (cond_code),
  .col       (uop_col),
  .seq_wr    (seq_wr),
  .ra_vec    (ra_vec),
  .rb_vec    (rb_vec),
  .rd_vec    (rd_vec),
  .cy_vec    (cy_vec),
  .mem_flat  (mem_flat),
  .seq_rdata (seq_rdata)
);

// File: tb/sim_bsp_array.sv
module sim_bsp_array;
  localparam int ROWS = 16;
  localparam int COLS = 32;
  localparam int M    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  t_op = 4'd0;
  logic [4:0]  t_col = 5'd0;
  logic [1:0]  t_src = 2'd0;
  logic [2:0]  t_fn = 3'd0;
  logic        t_imm = 1'b0;
  logic [1:0]  t_cc = 2'd0;
  logic        t_wr = 1'b0;
  logic [3:0]  t_row = 4'd0;
  logic [31:0] t_wd = 32'd0;
  logic [31:0] seq_rdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [31:0] mm [ROWS];
  logic [ROWS-1:0] m_ra = '0, m_rb = '0, m_rc = '0, m_rd = '0, m_cy = '0;
  int av [ROWS];
  int bv [ROWS];

  always #10 clk = ~clk;

  bsp_array u0 (
    .clk(clk), .rst_n(rst_n), .uop_op(t_op), .uop_col(t_col), .uop_src(t_src),
    .uop_fn(t_fn), .uop_imm(t_imm), .cond_code(t_cc), .seq_wr(t_wr),
    .seq_row(t_row), .seq_wdata(t_wd), .seq_rdata(seq_rdata)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_read();
    logic [31:0] v = '0;
    if (t_cc == 2'b10) begin
      for (int r = 0; r < ROWS; r++) if (m_rd[r]) v |= mm[r];
    end else v = mm[t_row];
    return v;
  endfunction

  task automatic mdl_update();
    logic [31:0] om [ROWS];
    logic [ROWS-1:0] ord;
    logic mb, bb, val;
    for (int r = 0; r < ROWS; r++) om[r] = mm[r];
    ord = m_rd;
    if (t_wr) begin
      for (int r = 0; r < ROWS; r++)
        if ((t_cc == 2'b10) ? ord[r] : (t_row == 4'(r))) mm[r] = t_wd;
    end
    for (int r = 0; r < ROWS; r++) begin
      mb = om[r][t_col];
      case (t_op)
        4'd1: m_ra[r] = mb;
        4'd2: m_rb[r] = (t_cc == 2'b00 && ord[r]) ? 1'b0 : mb;
        4'd3: m_rc[r] = mb;
        4'd4: begin
          if (t_cc == 2'b01) val = ord[r] ? m_rb[r] : m_ra[r];
          else case (t_src)
            2'd0: val = m_ra[r];
            2'd1: val = m_rb[r];
            2'd2: val = m_rc[r];
            default: val = m_cy[r];
          endcase
          mm[r][t_col] = val;
        end
        4'd5: begin
          bb = (t_fn == 3'd1) ? ~mb : mb;
          case (t_fn)
            3'd0, 3'd1: begin
              m_rc[r] = m_ra[r] ^ bb ^ m_cy[r];
              m_cy[r] = (m_ra[r] & bb) | (m_ra[r] & m_cy[r]) | (bb & m_cy[r]);
            end
            3'd2: m_rc[r] = m_ra[r] & mb;
            3'd3: m_rc[r] = m_ra[r] | mb;
            3'd4: m_rc[r] = m_ra[r] ^ mb;
            default: m_rc[r] = 1'b0;
          endcase
        end
        4'd6: m_cy[r] = 1'b0;
        4'd7: m_cy[r] = 1'b1;
        4'd8: m_rd[r] = 1'b1;
        4'd9: m_rd[r] = ord[r] & (mb == t_imm);
        default: ;
      endcase
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    mdl_update();
    @(negedge clk);
    check(seq_rdata, mdl_read(), "R6 model");
  endtask

  task automatic issue(input logic [3:0] op, input logic [4:0] col, input logic [1:0] src,
                       input logic [2:0] fn, input logic imm, input logic [1:0] cc);
    t_op = op; t_col = col; t_src = src; t_fn = fn; t_imm = imm; t_cc = cc; t_wr = 1'b0;
    cycle();
    t_op = 4'd0;
  endtask

  task automatic seqw(input logic [3:0] row, input logic [31:0] d, input logic [1:0] cc);
    t_op = 4'd0; t_wr = 1'b1; t_row = row; t_wd = d; t_cc = cc;
    cycle();
    t_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] row, input logic [1:0] cc, output logic [31:0] v);
    t_op = 4'd0; t_wr = 1'b0; t_row = row; t_cc = cc;
    #1 v = seq_rdata;
  endtask

  task automatic vec_op(input logic [2:0] fn, input bit arith);
    if (arith) issue((fn == 3'd1) ? 4'd7 : 4'd6, 5'd0, 2'd0, 3'd0, 1'b0, 2'd0);
    for (int i = 0; i < M; i++) begin
      issue(4'd1, 5'(i), 2'd0, 3'd0, 1'b0, 2'd0);
      issue(4'd5, 5'(M + i), 2'd0, fn, 1'b0, 2'd0);
      issue(4'd4, 5'(16 + i), 2'd2, 3'd0, 1'b0, 2'd0);
    end
    if (arith) issue(4'd4, 5'(16 + M), 2'd3, 3'd0, 1'b0, 2'd0);
  endtask

  task automatic tag_key(input logic [7:0] key);
    issue(4'd8, 5'd0, 2'd0, 3'd0, 1'b0, 2'd0);
    for (int i = 0; i < M; i++) issue(4'd9, 5'(i), 2'd0, 3'd0, key[i], 2'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, e;
    logic [7:0] key;
    for (int r = 0; r < ROWS; r++) mm[r] = '0;
    for (int r = 0; r < ROWS; r++) begin
      av[r] = (r * 37 + 11) & 255;
      bv[r] = (r * 91 + 200) & 255;
    end
    av[0] = 255; bv[0] = 255;
    av[1] = 0;   bv[1] = 0;
    av[2] = 3;   bv[2] = 200;

    repeat (3) @(negedge clk);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check(w, 32'd0, "R1 reset word");
    end
    rst_n = 1'b1;
    repeat (3) cycle();

    // R6: direct row access
    for (int r = 0; r < ROWS; r++) seqw(4'(r), {16'd0, 8'(bv[r]), 8'(av[r])}, 2'd0);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd3, w);
      check(w, {16'd0, 8'(bv[r]), 8'(av[r])}, "R6 row readback");
    end

    // R7: add
    vec_op(3'd0, 1'b1);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({23'd0, w[24:16]}, 32'(av[r] + bv[r]), "R7 add");
    end

    // R8: subtract
    vec_op(3'd1, 1'b1);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({24'd0, w[23:16]}, 32'((av[r] - bv[r]) & 255), "R8 difference");
      check({31'd0, w[24]}, (av[r] >= bv[r]) ? 32'd1 : 32'd0, "R8 no-borrow");
    end

    // R9: logic functions, carry kept
    vec_op(3'd2, 1'b0);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({24'd0, w[23:16]}, 32'(av[r] & bv[r]), "R9 and");
    end
    vec_op(3'd3, 1'b0);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({24'd0, w[23:16]}, 32'(av[r] | bv[r]), "R9 or");
    end
    vec_op(3'd4, 1'b0);
    issue(4'd4, 5'd25, 2'd3, 3'd0, 1'b0, 2'd0);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({24'd0, w[23:16]}, 32'(av[r] ^ bv[r]), "R9 xor");
      check({31'd0, w[25]}, (av[r] >= bv[r]) ? 32'd1 : 32'd0, "R9 carry kept");
    end

    // R2: load RC and store it to another column
    issue(4'd3, 5'd3, 2'd0, 3'd0, 1'b0, 2'd0);
    issue(4'd4, 5'd30, 2'd2, 3'd0, 1'b0, 2'd0);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({31'd0, w[30]}, 32'((av[r] >> 3) & 1), "R2 column copy");
    end

    // R10: compare-immediate flags the row holding row 5's A value
    key = 8'(av[5]);
    tag_key(key);
    e = '0;
    for (int r = 0; r < ROWS; r++) if (av[r] == int'(key)) e |= {16'd0, 8'(bv[r]), 8'(av[r])};
    peek(4'd0, 2'd2, w);
    check(w & 32'hFFFF, e, "R10 tagged read");

    // R3: conditional zero on RB load (A bit 2; row 5 has it set)
    issue(4'd2, 5'd2, 2'd0, 3'd0, 1'b0, 2'd0);
    issue(4'd4, 5'd29, 2'd1, 3'd0, 1'b0, 2'd0);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({31'd0, w[29]}, (av[r] == int'(key)) ? 32'd0 : 32'((av[r] >> 2) & 1), "R3 cond load");
    end

    // R4: write-select store
    issue(4'd1, 5'd0, 2'd0, 3'd0, 1'b0, 2'd1);
    issue(4'd2, 5'd8, 2'd0, 3'd0, 1'b0, 2'd1);
    issue(4'd4, 5'd28, 2'd2, 3'd0, 1'b0, 2'd1);
    for (int r = 0; r < ROWS; r++) begin
      peek(4'(r), 2'd0, w);
      check({31'd0, w[28]}, (av[r] == int'(key)) ? 32'(bv[r] & 1) : 32'(av[r] & 1), "R4 wsel store");
    end

    // R5: masked sequential write reaches only flagged rows
    seqw(4'd0, 32'h0000_0000, 2'd2);
    peek(4'd5, 2'd0, w);
    check(w, 32'd0, "R5 flagged row cleared");
    peek(4'd6, 2'd0, w);
    check(w & 32'hFFFF, {16'd0, 8'(bv[6]), 8'(av[6])}, "R5 unflagged row kept");

    // R5/R10: a key present in no row leaves an empty masked read
    key = 8'd1;
    for (int k = 1; k < 256; k++) begin
      bit used = 1'b0;
      for (int r = 0; r < ROWS; r++) if (r != 5 && av[r] == k) used = 1'b1;
      if (!used) begin key = 8'(k); break; end
    end
    tag_key(key);
    peek(4'd0, 2'd2, w);
    check(w, 32'd0, "R5 no match read");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule